// File: doc/BRIEF.md
# Vector compare branch with mask accumulation

This block executes a conditional branch that has been turned into a predicated element-wise compare. A command names two source registers. Each source is either a vector or a scalar. A vector source steps through consecutive registers, one per element. A scalar source supplies the same register for every element. For each element position below the vector length, the block reads both operands from the register file through two combinational read ports. Where the source predicate enables the element, the block evaluates the selected compare and records the outcome in a result mask. The branch is then resolved by comparing that mask with the predicate mask.

When a destination predicate register is present, the finished mask is handed back with a write strobe so the register can be updated. The caller supplies the register's current value as `cmd_dest_val`. A trap can arrive while the element loop runs. If a destination exists, the partial mask and the element offset are returned so that the command can be reissued later from that offset. If no destination exists, the loop starts again from element zero. When neither source is a vector, the command reduces to a single scalar compare.

Commands enter on a valid/ready pair. `cmd_ready` is high only while the block is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Results leave on a second valid/ready pair. `res_valid` and every `res_*` field stay constant until the consumer raises `res_ready`. The mask write happens at that handshake. The consumer may hold `res_ready` low for any number of cycles without losing the result.

Top module: `vcb_branch`

## Requirements
- R1: When neither source is a vector, one compare of register base1 against register base2 decides `res_taken`, `res_mask` is zero, `mask_we` stays low, and `res_valid` rises one cycle after the command is accepted.
- R2: `cmd_op` selects the compare: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal; codes 010 and 011 never hold.
- R3: For element e, a vector source reads index (base+e) modulo 2^RIDX_W and a scalar source reads its base index.
- R4: With start offset s, initial mask bit j is `cmd_dest_val[j]` when a destination is present and either j < s or zeroing is off; otherwise it is zero.
- R5: For each element e from s to VL-1, the block updates mask bit e as follows. If predicate bit e is set, the bit becomes the compare outcome. If predicate bit e is clear and zeroing is on, the bit is cleared. Otherwise the bit is kept. Bits at and above VL keep their initial value.
- R6: `mask_we` is high exactly in the result handshake cycle of a vector command that has a destination, with `res_mask` as write data.
- R7: For a vector command, `res_taken` is 1 if and only if no trap ended the command and all MAXVL bits of the result mask equal the predicate mask.
- R8: A trap during the loop with a destination present ends the command. The element in flight is not processed. The partial mask is returned, `res_trapped` is set, `res_offset` gives the unprocessed element, and `res_taken` is 0. Reissuing the command with the partial mask as destination value and that offset as start gives the uninterrupted result.
- R9: A trap during the loop with no destination resets the loop to element zero with a zero mask, and the command continues. The final result matches an untrapped run from element zero.
- R10: The loop processes one element per cycle, so `res_valid` rises VL−s cycles after acceptance. If s ≥ VL, it rises in the cycle after acceptance with the initial mask.
- R11: `cmd_ready` is high only when idle. The result fields hold while `res_valid` is high and `res_ready` is low. After the result handshake the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_op | input | 3 | Compare selection code |
| cmd_base1 | input | RIDX_W | First source register |
| cmd_base2 | input | RIDX_W | Second source register |
| cmd_vec1 | input | 1 | First source is a vector |
| cmd_vec2 | input | 1 | Second source is a vector |
| cmd_vl | input | VLW | Vector length |
| cmd_start | input | VLW | First element to process |
| cmd_pred | input | MAXVL | Source predicate mask |
| cmd_zero | input | 1 | Zeroing mode |
| cmd_has_dest | input | 1 | Destination predicate register present |
| cmd_dest_val | input | MAXVL | Current destination register value |
| trap | input | 1 | Trap request during the element loop |
| rd_idx1 | output | RIDX_W | Read index, first source |
| rd_idx2 | output | RIDX_W | Read index, second source |
| rd_data1 | input | XLEN | Read data, first source |
| rd_data2 | input | XLEN | Read data, second source |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumed |
| res_taken | output | 1 | Branch taken |
| res_mask | output | MAXVL | Result mask and write data |
| res_trapped | output | 1 | Command ended by a trap |
| res_offset | output | VLW | Element to resume at after a trap |
| mask_we | output | 1 | Destination mask write strobe |

## Verification
The bench builds the block with XLEN=4, RIDX_W=3 and MAXVL=4. With these values the bench can try every operand pair under every compare code on the scalar path. It can also cover every predicate mask at every vector length, with and without zeroing and a destination, for all three source pairings. Eight registers make vector indices wrap around the register file. A four-element loop makes it practical to inject a trap at every element position and to reissue every start offset. The bench checks the partial-mask, resume and restart behaviour at each of those points.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
  localparam logic [2:0] CMP_EQ  = 3'b000;
  localparam logic [2:0] CMP_NE  = 3'b001;
  localparam logic [2:0] CMP_LT  = 3'b100;
  localparam logic [2:0] CMP_GE  = 3'b101;
  localparam logic [2:0] CMP_LTU = 3'b110;
  localparam logic [2:0] CMP_GEU = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAL,
    ST_RUN,
    ST_DONE
  } vcb_state_e;
endpackage

// File: rtl/vcb_cmp.sv
module vcb_cmp
  import vcb_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            hit
);
  logic eq, lt_s, lt_u;

  assign eq   = (a == b);
  assign lt_s = ($signed(a) < $signed(b));
  assign lt_u = (a < b);

  always_comb begin
    case (op)
      CMP_EQ:  hit = eq;
      CMP_NE:  hit = !eq;
      CMP_LT:  hit = lt_s;
      CMP_GE:  hit = !lt_s;
      CMP_LTU: hit = lt_u;
      CMP_GEU: hit = !lt_u;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcb_maskreg.sv
module vcb_maskreg #(
  parameter int MAXVL = 16,
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VLW-1:0]   cmd_start,
  input  logic             cmd_zero,
  input  logic             cmd_has_dest,
  input  logic [MAXVL-1:0] cmd_dest_val,
  input  logic [MAXVL-1:0] cmd_pred,
  input  logic             restart,
  input  logic             upd,
  input  logic [VLW-1:0]   idx,
  input  logic             hit,
  output logic [MAXVL-1:0] mask,
  output logic [MAXVL-1:0] pred_q
);
  logic             zero_q;
  logic [MAXVL-1:0] sel;
  logic             cur_pred;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      zero_q <= 1'b0;
    end else if (load) begin
      pred_q <= cmd_pred;
      zero_q <= cmd_zero;
    end
  end

  for (genvar j = 0; j < MAXVL; j++) begin : g_bit
    logic keep_old;
    assign sel[j]   = (idx == VLW'(j));
    assign keep_old = (VLW'(j) < cmd_start) || !cmd_zero;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[j] <= 1'b0;
      end else if (load) begin
        mask[j] <= cmd_has_dest && keep_old && cmd_dest_val[j];
      end else if (restart) begin
        mask[j] <= 1'b0;
      end else if (upd && sel[j]) begin
        if (pred_q[j])   mask[j] <= hit;
        else if (zero_q) mask[j] <= 1'b0;
      end
    end
  end

  assign cur_pred = |(sel & pred_q);

  // R5: a masked-off element leaves the mask alone unless zeroing is on
  p_keep_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !cur_pred && !zero_q) |=> $stable(mask));

  // R5: a masked-off element under zeroing ends up cleared
  p_zero_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !cur_pred && zero_q) |=> ((mask & $past(sel)) == '0));
endmodule

// File: rtl/vcb_ctrl.sv
module vcb_ctrl
  import vcb_pkg::*;
#(
  parameter int RIDX_W = 7,
  parameter int MAXVL  = 16,
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [RIDX_W-1:0] cmd_base1,
  input  logic [RIDX_W-1:0] cmd_base2,
  input  logic              cmd_vec1,
  input  logic              cmd_vec2,
  input  logic [VLW-1:0]    cmd_vl,
  input  logic [VLW-1:0]    cmd_start,
  input  logic              cmd_has_dest,
  input  logic              trap,
  input  logic              cmp_hit,
  output logic [RIDX_W-1:0] rd_idx1,
  output logic [RIDX_W-1:0] rd_idx2,
  output logic              load,
  output logic              restart,
  output logic              upd,
  output logic [VLW-1:0]    idx,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              scalar_q,
  output logic              has_dest_q,
  output logic              trapped_q,
  output logic [VLW-1:0]    offset_q,
  output logic              taken_s_q
);
  vcb_state_e        state;
  logic [RIDX_W-1:0] base1_q, base2_q;
  logic              vec1_q, vec2_q;
  logic [VLW-1:0]    vl_q;
  logic [RIDX_W+VLW-1:0] sum1, sum2;

  assign cmd_ready = (state == ST_IDLE);
  assign res_valid = (state == ST_DONE);
  assign load      = cmd_ready && cmd_valid;
  assign restart   = (state == ST_RUN) && trap && !has_dest_q;
  assign upd       = (state == ST_RUN) && !trap;

  assign sum1    = {{VLW{1'b0}}, base1_q} + {{RIDX_W{1'b0}}, idx};
  assign sum2    = {{VLW{1'b0}}, base2_q} + {{RIDX_W{1'b0}}, idx};
  assign rd_idx1 = vec1_q ? sum1[RIDX_W-1:0] : base1_q;
  assign rd_idx2 = vec2_q ? sum2[RIDX_W-1:0] : base2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      base1_q    <= '0;
      base2_q    <= '0;
      vec1_q     <= 1'b0;
      vec2_q     <= 1'b0;
      vl_q       <= '0;
      idx        <= '0;
      scalar_q   <= 1'b0;
      has_dest_q <= 1'b0;
      trapped_q  <= 1'b0;
      offset_q   <= '0;
      taken_s_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          base1_q    <= cmd_base1;
          base2_q    <= cmd_base2;
          vec1_q     <= cmd_vec1;
          vec2_q     <= cmd_vec2;
          vl_q       <= cmd_vl;
          has_dest_q <= cmd_has_dest;
          scalar_q   <= !(cmd_vec1 || cmd_vec2);
          trapped_q  <= 1'b0;
          offset_q   <= '0;
          taken_s_q  <= 1'b0;
          idx        <= '0;
          if (!(cmd_vec1 || cmd_vec2)) begin
            state <= ST_SCAL;
          end else if (cmd_start >= cmd_vl) begin
            state <= ST_DONE;
          end else begin
            state <= ST_RUN;
            idx   <= cmd_start;
          end
        end
        ST_SCAL: begin
          taken_s_q <= cmp_hit;
          state     <= ST_DONE;
        end
        ST_RUN: begin
          if (trap) begin
            if (has_dest_q) begin
              trapped_q <= 1'b1;
              offset_q  <= idx;
              state     <= ST_DONE;
            end else begin
              idx <= '0;
            end
          end else if (idx == vl_q - VLW'(1)) begin
            state <= ST_DONE;
          end else begin
            idx <= idx + VLW'(1);
          end
        end
        default: if (res_ready) state <= ST_IDLE;
      endcase
    end
  end

  // R10: the element counter never reaches the vector length inside the loop
  p_idx_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (idx < vl_q));

  // R9: trap without a destination rewinds to element zero and keeps looping
  p_trap_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && trap && !has_dest_q) |=> (state == ST_RUN && idx == '0));

  // R8: trap with a destination ends the command and records the offset
  p_trap_save_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && trap && has_dest_q)
      |=> (res_valid && trapped_q && offset_q == $past(idx)));
endmodule

// File: rtl/vcb_branch.sv
module vcb_branch #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 7,
  parameter int MAXVL  = 16,
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [RIDX_W-1:0] cmd_base1,
  input  logic [RIDX_W-1:0] cmd_base2,
  input  logic              cmd_vec1,
  input  logic              cmd_vec2,
  input  logic [VLW-1:0]    cmd_vl,
  input  logic [VLW-1:0]    cmd_start,
  input  logic [MAXVL-1:0]  cmd_pred,
  input  logic              cmd_zero,
  input  logic              cmd_has_dest,
  input  logic [MAXVL-1:0]  cmd_dest_val,
  input  logic              trap,
  output logic [RIDX_W-1:0] rd_idx1,
  output logic [RIDX_W-1:0] rd_idx2,
  input  logic [XLEN-1:0]   rd_data1,
  input  logic [XLEN-1:0]   rd_data2,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_taken,
  output logic [MAXVL-1:0]  res_mask,
  output logic              res_trapped,
  output logic [VLW-1:0]    res_offset,
  output logic              mask_we
);
  logic [2:0]       op_q;
  logic             hit;
  logic             load, restart, upd;
  logic [VLW-1:0]   idx;
  logic             scalar_q, has_dest_q, trapped_q, taken_s_q;
  logic [MAXVL-1:0] mask, pred_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    op_q <= '0;
    else if (load) op_q <= cmd_op;
  end

  vcb_cmp #(.XLEN(XLEN)) u_cmp (
    .op  (op_q),
    .a   (rd_data1),
    .b   (rd_data2),
    .hit (hit)
  );

  vcb_ctrl #(.RIDX_W(RIDX_W), .MAXVL(MAXVL)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_base1    (cmd_base1),
    .cmd_base2    (cmd_base2),
    .cmd_vec1     (cmd_vec1),
    .cmd_vec2     (cmd_vec2),
    .cmd_vl       (cmd_vl),
    .cmd_start    (cmd_start),
    .cmd_has_dest (cmd_has_dest),
    .trap         (trap),
    .cmp_hit      (hit),
    .rd_idx1      (rd_idx1),
    .rd_idx2      (rd_idx2),
    .load         (load),
    .restart      (restart),
    .upd          (upd),
    .idx          (idx),
    .res_valid    (res_valid),
    .res_ready    (res_ready),
    .scalar_q     (scalar_q),
    .has_dest_q   (has_dest_q),
    .trapped_q    (trapped_q),
    .offset_q     (res_offset),
    .taken_s_q    (taken_s_q)
  );

  vcb_maskreg #(.MAXVL(MAXVL)) u_mask (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .cmd_start    (cmd_start),
    .cmd_zero     (cmd_zero),
    .cmd_has_dest (cmd_has_dest),
    .cmd_dest_val (cmd_dest_val),
    .cmd_pred     (cmd_pred),
    .restart      (restart),
    .upd          (upd),
    .idx          (idx),
    .hit          (hit),
    .mask         (mask),
    .pred_q       (pred_q)
  );

  assign res_trapped = trapped_q;
  assign res_mask    = scalar_q ? '0 : mask;
  assign res_taken   = scalar_q ? taken_s_q : (!trapped_q && (mask == pred_q));
  assign mask_we     = res_valid && res_ready && has_dest_q && !scalar_q;

  // R11: an unconsumed result holds every field
  p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready)
      |=> (res_valid && $stable(res_mask) && $stable(res_taken)
           && $stable(res_trapped) && $stable(res_offset)));

  // R11: no command is taken while a result waits
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cmd_ready);
endmodule

// File: tb/vcb_branch_test.sv
module vcb_branch_test;
  localparam int XLEN = 4;
  localparam int RIDX_W = 3;
  localparam int MAXVL = 4;
  localparam int VLW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [RIDX_W-1:0] cmd_base1 = '0, cmd_base2 = '0;
  logic cmd_vec1 = 1'b0, cmd_vec2 = 1'b0;
  logic [VLW-1:0] cmd_vl = '0, cmd_start = '0;
  logic [MAXVL-1:0] cmd_pred = '0, cmd_dest_val = '0;
  logic cmd_zero = 1'b0, cmd_has_dest = 1'b0;
  logic trap = 1'b0;
  logic [RIDX_W-1:0] rd_idx1, rd_idx2;
  logic [XLEN-1:0] rd_data1, rd_data2;
  logic res_valid;
  logic res_ready = 1'b0;
  logic res_taken;
  logic [MAXVL-1:0] res_mask;
  logic res_trapped;
  logic [VLW-1:0] res_offset;
  logic mask_we;

  logic [XLEN-1:0] rf [8];
  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  assign rd_data1 = rf[rd_idx1];
  assign rd_data2 = rf[rd_idx2];

  vcb_branch #(.XLEN(XLEN), .RIDX_W(RIDX_W), .MAXVL(MAXVL)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_base1(cmd_base1), .cmd_base2(cmd_base2),
    .cmd_vec1(cmd_vec1), .cmd_vec2(cmd_vec2), .cmd_vl(cmd_vl),
    .cmd_start(cmd_start), .cmd_pred(cmd_pred), .cmd_zero(cmd_zero),
    .cmd_has_dest(cmd_has_dest), .cmd_dest_val(cmd_dest_val), .trap(trap),
    .rd_idx1(rd_idx1), .rd_idx2(rd_idx2), .rd_data1(rd_data1),
    .rd_data2(rd_data2), .res_valid(res_valid), .res_ready(res_ready),
    .res_taken(res_taken), .res_mask(res_mask), .res_trapped(res_trapped),
    .res_offset(res_offset), .mask_we(mask_we)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit cmpf(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b);
    int sa, sb;
    sa = a[3] ? int'(a) - 16 : int'(a);
    sb = b[3] ? int'(b) - 16 : int'(b);
    case (op)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return sa < sb;
      3'd5: return sa >= sb;
      3'd6: return int'(a) < int'(b);
      3'd7: return int'(a) >= int'(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int ridx(input int base, input bit v, input int e);
    return v ? (base + e) % 8 : base;
  endfunction

  function automatic logic [3:0] model(input logic [2:0] op, input int b1, input int b2,
      input bit v1, input bit v2, input int start, input int endx,
      input logic [3:0] pred, input bit zero, input bit hasd, input logic [3:0] dval);
    logic [3:0] m;
    for (int j = 0; j < 4; j++)
      m[j] = hasd && (j < start || !zero) && dval[j];
    for (int i = start; i < endx; i++) begin
      if (pred[i]) m[i] = cmpf(op, rf[ridx(b1, v1, i)], rf[ridx(b2, v2, i)]);
      else if (zero) m[i] = 1'b0;
    end
    return m;
  endfunction

  task automatic fill();
    for (int k = 0; k < 8; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rf[k] = lfsr[3:0] ^ lfsr[11:8];
    end
  endtask

  task automatic run(input logic [2:0] op, input int b1, input int b2, input bit v1,
      input bit v2, input int vl, input int start, input logic [3:0] pred,
      input bit zero, input bit hasd, input logic [3:0] dval, input int trap_at,
      output logic [3:0] got_mask, output int got_off);
    int c, lat, endx, n;
    bit scal, trapped, tk;
    logic [3:0] em;
    scal = !(v1 || v2);
    n = (vl > start) ? vl - start : 0;
    @(negedge clk);
    cmd_op = op; cmd_base1 = 3'(b1); cmd_base2 = 3'(b2);
    cmd_vec1 = v1; cmd_vec2 = v2; cmd_vl = 3'(vl); cmd_start = 3'(start);
    cmd_pred = pred; cmd_zero = zero; cmd_has_dest = hasd; cmd_dest_val = dval;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    c = 0;
    while (!res_valid && c < 40) begin
      if (trap_at < 0 && !scal && c < n) begin
        chk(int'(rd_idx1) == ridx(b1, v1, start + c), "R3 idx1", int'(rd_idx1), ridx(b1, v1, start + c));
        chk(int'(rd_idx2) == ridx(b2, v2, start + c), "R3 idx2", int'(rd_idx2), ridx(b2, v2, start + c));
      end
      trap = (c == trap_at);
      @(posedge clk);
      @(negedge clk);
      trap = 1'b0;
      c++;
    end
    trapped = 1'b0;
    if (scal) begin
      lat = 1;
      em = 4'd0;
      tk = cmpf(op, rf[b1], rf[b2]);
    end else begin
      if (trap_at >= 0 && hasd) begin
        endx = start + trap_at;
        trapped = 1'b1;
        lat = trap_at + 1;
        em = model(op, b1, b2, v1, v2, start, endx, pred, zero, hasd, dval);
      end else if (trap_at >= 0) begin
        lat = trap_at + 1 + vl;
        em = model(op, b1, b2, v1, v2, 0, vl, pred, zero, hasd, dval);
      end else begin
        lat = n;
        em = model(op, b1, b2, v1, v2, start, vl, pred, zero, hasd, dval);
      end
      tk = !trapped && (em == pred);
    end
    if (scal) begin
      chk(res_taken == tk, "R1 R2 scalar taken", int'(res_taken), int'(tk));
      chk(res_mask == 4'd0, "R1 scalar mask", int'(res_mask), 0);
    end else begin
      chk(res_mask == em, trapped ? "R8 partial mask" : (trap_at >= 0 ? "R9 restart mask" : "R4 R5 mask"),
          int'(res_mask), int'(em));
      chk(res_taken == tk, "R7 taken", int'(res_taken), int'(tk));
      chk(res_trapped == trapped, "R8 trapped flag", int'(res_trapped), int'(trapped));
      if (trapped) chk(int'(res_offset) == start + trap_at, "R8 offset", int'(res_offset), start + trap_at);
    end
    chk(c == lat, scal ? "R1 latency" : "R10 latency", c, lat);
    got_mask = res_mask;
    got_off = int'(res_offset);
    em = res_mask;
    tk = res_taken;
    @(posedge clk);
    @(negedge clk);
    chk(res_valid && res_mask == em && res_taken == tk && !mask_we, "R11 hold", int'(res_mask), int'(em));
    res_ready = 1'b1;
    #1;
    chk(mask_we == (!scal && hasd), "R6 write strobe", int'(mask_we), int'(!scal && hasd));
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && cmd_ready, "R11 idle again", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] gm, gm2, ref_m;
    int go, go2;
    for (int k = 0; k < 8; k++) rf[k] = 4'(k);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready && !res_valid && !mask_we, "R11 reset state", int'(cmd_ready), 1);
    rst_n = 1'b1;

    // scalar path, every compare code and operand pair
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          rf[1] = 4'(a);
          rf[5] = 4'(b);
          run(3'(op), 1, 5, 1'b0, 1'b0, 2, 0, 4'(a), b[0], a[0], 4'(b), -1, gm, go);
        end

    // vector sweep across pairings, lengths, masks, zeroing, destination
    for (int op = 0; op < 8; op++)
      for (int mode = 1; mode < 4; mode++)
        for (int vl = 1; vl <= 4; vl++)
          for (int p = 0; p < 16; p++)
            for (int z = 0; z < 2; z++)
              for (int d = 0; d < 2; d++) begin
                fill();
                run(3'(op), 6, 2, mode[0], mode[1], vl, 0, 4'(p), z[0], d[0],
                    lfsr[7:4], -1, gm, go);
              end

    // start offsets, including start at and past the length
    for (int s = 0; s <= 4; s++)
      for (int vl = 1; vl <= 4; vl++)
        for (int z = 0; z < 2; z++)
          for (int p = 0; p < 16; p += 5) begin
            fill();
            run(3'd6, 3, 7, 1'b1, 1'b0, vl, s, 4'(p), z[0], 1'b1, lfsr[9:6], -1, gm, go);
          end

    // traps at every element, with resume or restart
    for (int vl = 2; vl <= 4; vl++)
      for (int t = 0; t < vl; t++)
        for (int z = 0; z < 2; z++)
          for (int op = 4; op < 8; op++)
            for (int p = 0; p < 16; p++) begin
              fill();
              ref_m = model(3'(op), 5, 1, 1'b1, 1'b1, 0, vl, 4'(p), z[0], 1'b1, lfsr[5:2]);
              run(3'(op), 5, 1, 1'b1, 1'b1, vl, 0, 4'(p), z[0], 1'b1, lfsr[5:2], t, gm, go);
              run(3'(op), 5, 1, 1'b1, 1'b1, vl, go, 4'(p), z[0], 1'b1, gm, -1, gm2, go2);
              chk(gm2 == ref_m, "R8 resume equals uninterrupted", int'(gm2), int'(ref_m));
              run(3'(op), 5, 1, 1'b1, 1'b0, vl, 0, 4'(p), z[0], 1'b0, 4'd0, t, gm, go);
            end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule